// File: doc/BRIEF.md
# Floppy Head Stepper Phase Tracker

This block follows the head of a disk drive as the host drives its four-phase stepper motor through soft-switch accesses. Each access carries a low address nibble. Odd nibbles in the lower half of the range energize one phase. All other nibbles, including the phase-off accesses, are ignored. The block keeps only the most recently energized phase. When a new phase arrives, a lookup indexed by the old and new phase decides whether the head moves one half-track inward, one half-track outward, or stays where it is.

The half-track position is held in a register that saturates at both ends. From this position and an externally kept sector counter, the block forms a byte offset into the disk image: the whole-track index times the encoded track length, plus the sector position. The motor-on logic is outside the block and tells it, through one input, whether the drive is online. The block ignores every request while the drive is offline.

Top module: `head_stepper_tracker`

## Requirements
- R1: After reset, `head_phase` is 0 (no phase energized yet), `head_pos` is 0 and `head_step` is 0.
- R2: A strobed access while online with nibble 0x1, 0x3, 0x5 or 0x7 sets `head_phase` to 1, 2, 3 or 4 on the next clock edge, and it does so even when the step is zero.
- R3: A strobed access with any other nibble (every even value, and the odd values 0x9 to 0xF) leaves `head_phase` and `head_pos` unchanged and gives `head_step` = 0.
- R4: Moving to the next phase in circular order (1 to 2, 2 to 3, 3 to 4, 4 to 1) gives `head_step` = +1 (2'b01) and raises `head_pos` by one.
- R5: Moving to the previous phase in circular order (2 to 1, 3 to 2, 4 to 3, 1 to 4) gives `head_step` = -1 (2'b11) and lowers `head_pos` by one.
- R6: Re-energizing the same phase, energizing the opposite phase (1/3 or 2/4), or any access made while `head_phase` is 0 gives `head_step` = 0 and leaves `head_pos` unchanged.
- R7: While `online` is low, a strobed access changes neither `head_phase` nor `head_pos`, and `head_step` stays 0.
- R8: An outward step at position 0 leaves `head_pos` at 0, while `head_step` still reports -1.
- R9: `head_pos` never exceeds MAX_HALF (default 70). An inward step at MAX_HALF leaves the position there.
- R10: `image_offset` equals (`head_pos` / 2, rounded down) × TRACK_BYTES + `sector_pos`. It is registered from the position being written and the sector value present at the same clock edge.
- R11: A head step does not disturb the sector contribution. Right after a step, the offset still adds the unchanged `sector_pos`.
- R12: `head_step` is non-zero only in the cycle right after an accepted strobe. It returns to 0 on the next edge unless another strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_strobe | input | 1 | One-cycle marker of a phase soft-switch access |
| access_nib | input | 4 | Low address nibble of the access |
| online | input | 1 | Drive is online; requests are ignored when low |
| sector_pos | input | SECW | Current byte position inside the track |
| head_phase | output | 3 | Last energized phase, 0 to 4 |
| head_step | output | 2 | Movement of the last cycle, two's complement -1/0/+1 |
| head_pos | output | POSW | Half-track position, 0 to MAX_HALF |
| image_offset | output | OFFW | Byte offset into the disk image |

## Verification
The hardest condition to reach from the ports is the upper limit of the head position. It takes seventy consecutive inward transitions in correct circular order, and a single opposite or repeated phase anywhere in the run stalls the climb. The bench therefore drives a generated walk of eighty accesses that rotates through the phases. It then checks that the position stops at the limit while the step output still reports inward motion. The lower limit and the wrap-around transitions between phases 4 and 1 are reached inside the vector table. That table also interleaves ignored nibbles and offline accesses, so that state left unchanged by one access can be seen to influence the next.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  typedef logic [2:0]        phase_t;
  typedef logic signed [1:0] step_t;

  localparam phase_t PH_NONE = 3'd0;
  localparam int     NPH     = 5;

  // Phase selected by a soft-switch nibble, PH_NONE if the nibble selects none.
  function automatic phase_t nib_to_phase(input logic [3:0] nib);
    if (!nib[3] && nib[0]) return phase_t'({1'b0, nib[2:1]}) + phase_t'(1);
    return PH_NONE;
  endfunction

  // Movement for a transition from prev to nxt on the circular phase ring.
  function automatic step_t phase_step(input phase_t prev, input phase_t nxt);
    logic [2:0] diff;
    if (prev == PH_NONE || nxt == PH_NONE) return 2'sd0;
    diff = nxt - prev;
    case (diff[1:0])
      2'd1:    return 2'sd1;
      2'd3:    return -2'sd1;
      default: return 2'sd0;
    endcase
  endfunction

  // Saturating position update.
  function automatic int clamp_pos(input int pos, input int step, input int hi);
    int t;
    t = pos + step;
    if (t < 0)  return 0;
    if (t > hi) return hi;
    return t;
  endfunction

  // Whole-track index times encoded track length plus the sector position.
  function automatic int image_byte(input int pos, input int sec, input int track_bytes);
    return (pos >>> 1) * track_bytes + sec;
  endfunction

endpackage

// File: rtl/phase_decoder.sv
module phase_decoder
  import stepper_pkg::*;
(
  input  logic       strobe,
  input  logic       online,
  input  logic [3:0] nib,
  output logic       accept,
  output phase_t     new_phase
);

  always_comb begin
    new_phase = nib_to_phase(nib);
    accept    = strobe && online && (new_phase != PH_NONE);
  end

endmodule

// File: rtl/step_table.sv
module step_table
  import stepper_pkg::*;
(
  input  phase_t prev,
  input  phase_t nxt,
  output step_t  step
);

  localparam int ENTRIES = NPH * NPH;

  step_t tbl [ENTRIES];

  for (genvar gp = 0; gp < NPH; gp++) begin : g_prev
    for (genvar gn = 0; gn < NPH; gn++) begin : g_next
      assign tbl[gp*NPH + gn] = phase_step(phase_t'(gp), phase_t'(gn));
    end
  end

  logic [5:0] idx;

  always_comb begin
    idx  = 6'(prev) * 6'(NPH) + 6'(nxt);
    step = 2'sd0;
    if (prev < phase_t'(NPH) && nxt < phase_t'(NPH)) step = tbl[idx[4:0]];
  end

endmodule

// File: rtl/head_position.sv
module head_position
  import stepper_pkg::*;
#(
  parameter int MAX_HALF = 70,
  parameter int POSW     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  step_t           step,
  output logic [POSW-1:0] pos_q,
  output logic [POSW-1:0] pos_d
);

  always_comb begin
    pos_d = pos_q;
    if (accept) pos_d = POSW'(clamp_pos(int'(pos_q), int'(step), MAX_HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

endmodule

// File: rtl/img_offset_calc.sv
module img_offset_calc
  import stepper_pkg::*;
#(
  parameter int TRACK_BYTES = 6384,
  parameter int POSW        = 7,
  parameter int SECW        = 13,
  parameter int OFFW        = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [POSW-1:0] pos_d,
  input  logic [SECW-1:0] sector,
  output logic [OFFW-1:0] offset_q
);

  logic [OFFW-1:0] offset_d;

  always_comb offset_d = OFFW'(image_byte(int'(pos_d), int'(sector), TRACK_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offset_q <= '0;
    else        offset_q <= offset_d;
  end

endmodule

// File: rtl/head_stepper_tracker.sv
module head_stepper_tracker
  import stepper_pkg::*;
#(
  parameter int  MAX_HALF    = 70,
  parameter int  TRACK_BYTES = 6384,
  localparam int POSW        = $clog2(MAX_HALF + 1),
  localparam int SECW        = $clog2(TRACK_BYTES),
  localparam int OFFW        = $clog2((MAX_HALF / 2) * TRACK_BYTES + TRACK_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            access_strobe,
  input  logic [3:0]      access_nib,
  input  logic            online,
  input  logic [SECW-1:0] sector_pos,
  output logic [2:0]      head_phase,
  output logic [1:0]      head_step,
  output logic [POSW-1:0] head_pos,
  output logic [OFFW-1:0] image_offset
);

  // Internal events, named for the checker.
  logic   accept_w;
  phase_t req_phase_w;
  step_t  table_step_w;
  logic [POSW-1:0] pos_d_w;

  phase_t phase_q;
  step_t  step_q;

  phase_decoder u_dec (
    .strobe    (access_strobe),
    .online    (online),
    .nib       (access_nib),
    .accept    (accept_w),
    .new_phase (req_phase_w)
  );

  step_table u_tbl (
    .prev (phase_q),
    .nxt  (req_phase_w),
    .step (table_step_w)
  );

  head_position #(.MAX_HALF(MAX_HALF), .POSW(POSW)) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept_w),
    .step   (table_step_w),
    .pos_q  (head_pos),
    .pos_d  (pos_d_w)
  );

  img_offset_calc #(
    .TRACK_BYTES(TRACK_BYTES), .POSW(POSW), .SECW(SECW), .OFFW(OFFW)
  ) u_off (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos_d    (pos_d_w),
    .sector   (sector_pos),
    .offset_q (image_offset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_NONE;
      step_q  <= 2'sd0;
    end else begin
      step_q <= accept_w ? table_step_w : 2'sd0;
      if (accept_w) phase_q <= req_phase_w;
    end
  end

  assign head_phase = phase_q;
  assign head_step  = step_q;

endmodule

// File: rtl/head_stepper_chk.sv
module head_stepper_chk #(
  parameter int MAX_HALF = 70,
  parameter int POSW     = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            strobe,
  input logic            online,
  input logic [3:0]      nib,
  input logic [2:0]      phase_q,
  input logic [1:0]      step_q,
  input logic [POSW-1:0] pos_q,
  input logic            accept
);

  // R9: position never exceeds the upper limit
  p_pos_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) <= MAX_HALF);

  // R7: offline requests change nothing
  p_offline_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !online) |=> ($stable(phase_q) && $stable(pos_q) && step_q == 2'b00));

  // R3: phase-off nibbles change nothing
  p_even_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !nib[0]) |=> ($stable(phase_q) && $stable(pos_q) && step_q == 2'b00));

  // R6: no movement out of the no-phase state
  p_from_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && phase_q == 3'd0) |=> (step_q == 2'b00));

  // R4: inward step raises the position, saturating at the limit
  p_inward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == 2'b01) |-> (int'(pos_q) ==
      ((int'($past(pos_q)) >= MAX_HALF) ? MAX_HALF : int'($past(pos_q)) + 1)));

  // R8: outward step lowers the position, saturating at zero
  p_outward_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == 2'b11) |-> (int'(pos_q) ==
      ((int'($past(pos_q)) == 0) ? 0 : int'($past(pos_q)) - 1)));

  // R12: without an accepted request the step output is zero and the position holds
  p_step_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (step_q == 2'b00 && $stable(pos_q)));

  // R2: an accepted request leaves a real phase latched
  p_phase_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase_q != 3'd0 && phase_q <= 3'd4));

endmodule

bind head_stepper_tracker head_stepper_chk #(.MAX_HALF(MAX_HALF), .POSW(POSW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .strobe  (access_strobe),
  .online  (online),
  .nib     (access_nib),
  .phase_q (head_phase),
  .step_q  (head_step),
  .pos_q   (head_pos),
  .accept  (accept_w)
);

// File: tb/sim_head_stepper_tracker.sv
`timescale 1ns/1ps
module sim_head_stepper_tracker;

  localparam int MAXH = 70;
  localparam int TB   = 6384;
  localparam int SECW = $clog2(TB);
  localparam int POSW = $clog2(MAXH + 1);
  localparam int OFFW = $clog2((MAXH / 2) * TB + TB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [3:0] nib = 4'h0;
  logic online = 1'b1;
  logic [SECW-1:0] sector = '0;
  logic [2:0] phase;
  logic [1:0] step;
  logic [POSW-1:0] pos;
  logic [OFFW-1:0] offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  head_stepper_tracker #(.MAX_HALF(MAXH), .TRACK_BYTES(TB)) u0 (
    .clk(clk), .rst_n(rst_n), .access_strobe(strobe), .access_nib(nib),
    .online(online), .sector_pos(sector), .head_phase(phase),
    .head_step(step), .head_pos(pos), .image_offset(offset)
  );

  // {online, nibble, expected phase, expected position, expected step}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 4'h1, 3'd1, 7'd0, 2'b00},  // R6 from no phase
    {1'b1, 4'h3, 3'd2, 7'd1, 2'b01},  // R4
    {1'b1, 4'h5, 3'd3, 7'd2, 2'b01},  // R4
    {1'b1, 4'h7, 3'd4, 7'd3, 2'b01},  // R4
    {1'b1, 4'h1, 3'd1, 7'd4, 2'b01},  // R4 wrap 4 to 1
    {1'b1, 4'h0, 3'd1, 7'd4, 2'b00},  // R3 phase-off
    {1'b1, 4'h5, 3'd3, 7'd4, 2'b00},  // R6 opposite
    {1'b1, 4'h3, 3'd2, 7'd3, 2'b11},  // R5
    {1'b1, 4'h1, 3'd1, 7'd2, 2'b11},  // R5
    {1'b1, 4'h7, 3'd4, 7'd1, 2'b11},  // R5 wrap 1 to 4
    {1'b1, 4'h7, 3'd4, 7'd1, 2'b00},  // R6 same phase
    {1'b0, 4'h1, 3'd4, 7'd1, 2'b00},  // R7 offline
    {1'b1, 4'h9, 3'd4, 7'd1, 2'b00},  // R3 high odd nibble
    {1'b1, 4'h5, 3'd3, 7'd0, 2'b11},  // R5
    {1'b1, 4'h3, 3'd2, 7'd0, 2'b11},  // R8 clamp at zero
    {1'b1, 4'h6, 3'd2, 7'd0, 2'b00}   // R3
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic on, input logic [3:0] n);
    @(negedge clk);
    online = on; nib = n; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0; online = 1'b1;
  endtask

  function automatic int exp_off(input int p, input int s);
    return (p / 2) * TB + s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ph;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 phase", int'(phase), 0);
    check("R1 pos", int'(pos), 0);
    check("R1 step", int'(step), 0);

    for (int i = 0; i < NV; i++) begin
      sector = SECW'(i * 37 + 5);
      access(VEC[i][16], VEC[i][15:12]);
      check($sformatf("R2/R3 phase v%0d", i), int'(phase), int'(VEC[i][11:9]));
      check($sformatf("R4/R5 pos v%0d", i), int'(pos), int'(VEC[i][8:2]));
      check($sformatf("R6 step v%0d", i), int'(step), int'(VEC[i][1:0]));
      check($sformatf("R10 offset v%0d", i), int'(offset), exp_off(int'(VEC[i][8:2]), i * 37 + 5));
    end

    // R12: step pulse clears on the idle edge
    access(1'b1, 4'h5);
    check("R12 step after access", int'(step), 1);
    @(negedge clk);
    check("R12 step idle", int'(step), 0);
    check("R12 pos hold", int'(pos), 1);

    // R9 / R11: climb past the top with constant sector
    sector = SECW'(1234);
    ph = 3;
    for (int k = 0; k < 80; k++) begin
      ph = (ph % 4) + 1;
      access(1'b1, 4'(2 * ph - 1));
    end
    check("R9 pos clamped", int'(pos), MAXH);
    check("R9 step still inward", int'(step), 1);
    check("R11 offset keeps sector", int'(offset), exp_off(MAXH, 1234));
    ph = (ph == 1) ? 4 : ph - 1;
    access(1'b1, 4'(2 * ph - 1));
    check("R5 leave top", int'(pos), MAXH - 1);
    check("R11 offset after step", int'(offset), exp_off(MAXH - 1, 1234));
    sector = SECW'(77);
    @(negedge clk);
    check("R10 offset follows sector", int'(offset), exp_off(MAXH - 1, 77));

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset phase", int'(phase), 0);
    check("R1 reset pos", int'(pos), 0);
    rst_n = 1'b1;
    access(1'b1, 4'h3);
    check("R6 after reset", int'(step), 0);
    check("R2 after reset", int'(phase), 2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule